// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers up to `N` peripheral interrupt lines into a single request to a processor core. Each line latches into a pending flag. The flag stays set until software clears it by writing a one to its bit. Every source also has an enable bit and a level bit, and the level bit places the source in the high or the low class. The controller picks one winner. Any eligible high-class source beats every low-class source. Inside a class, the lowest source index wins.

The controller presents the winner to the core with a request, a level flag and a 21-bit service address. In table mode, the address is a programmable table base plus twice the winner's index. With table mode off, the address is one of two fixed entry points, chosen by level. The table base can be write-protected by a lock bit. A configuration input can make that lock one-way, so that once set it stays set until reset. The core takes a request with an acknowledge pulse and ends a service routine with a return pulse. The block tracks two nesting levels and reports whether high-level service, low-level service or neither is running.

Software reaches the controller over a simple addressed bus with a single-cycle write strobe and a combinational read port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A source line that is high at a clock edge sets its pending bit, which is read at bus address 1. The bit is cleared only by a bus write to address 1 that has a one in that bit position; writing a zero leaves it set. If the line sets a bit at the same edge that a write clears it, the set wins.
- R2: A source whose enable bit (address 2, bit i for source i) is zero never causes a request, whatever its pending state.
- R3: The level bit of source i (address 3, 1 = high) decides its class. When a high-class source is pending, enabled and allowed, the request is at high level (`core_hi_o` = 1), even if low-class sources are also pending.
- R4: Within one class, the source with the lowest index wins.
- R5: With `vec_mode_i` = 1, `core_vec_o` equals the table base plus two times the winning index, modulo 2^21.
- R6: The table base is held in bits 20:0 of address 4. Writes to it are ignored while the lock bit (address 5, bit 0) is one.
- R7: With `one_way_i` = 0, the lock bit can be set and cleared by writes. With `one_way_i` = 1, a write of zero does not clear a set lock.
- R8: With `vec_mode_i` = 0, the address is 0x000008 for a high-level request and 0x000018 for a low-level request.
- R9: Address 0 bit 0 is the global enable for the high class, and bit 1 is the global enable for the low class. A class whose global enable is zero raises no request.
- R10: An acknowledge while a request is raised enters service at the request's level. A high request can preempt low service. No request is raised during high service, and a low request is raised only when no service is active. A return pulse leaves the innermost level. `exec_hi_o` and `exec_lo_o` (also address 6, bits 0 and 1) show running high and running low service.
- R11: After reset, the global enables, pending bits, enables and lock are zero, every level bit is one, the table base is 0x000008, no service is active and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_irq_i | input | N | Peripheral interrupt lines, sampled each edge |
| vec_mode_i | input | 1 | 1 = table addresses, 0 = two fixed entry points |
| one_way_i | input | 1 | 1 = lock cannot be cleared once set |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i` (combinational) |
| core_req_o | output | 1 | Interrupt request to the core |
| core_hi_o | output | 1 | Level of the current request, 1 = high |
| core_vec_o | output | 21 | Service address for the current request |
| core_ack_i | input | 1 | Core accepts the current request |
| core_ret_i | input | 1 | Core returns from the innermost service |
| exec_hi_o | output | 1 | High-level service running |
| exec_lo_o | output | 1 | Low-level service running, not preempted |

## Verification
The nesting checks assume that the core acknowledges only while a request is raised, returns only from a service it has entered, and never acknowledges and returns in the same cycle. The bench keeps to these rules. It raises `core_ack_i` only after it has seen `core_req_o` high, and it issues exactly one return for each acknowledged entry. It also changes `one_way_i` only after the lock has been cleared. As a result, the one-way test starts from an unlocked state and does not rely on a mode change taking effect in the middle of a lock.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

   // register map of the bus port
   typedef enum logic [2:0] {
      RA_GCTL   = 3'd0,
      RA_PEND   = 3'd1,
      RA_ENA    = 3'd2,
      RA_LEVEL  = 3'd3,
      RA_BASE   = 3'd4,
      RA_LOCK   = 3'd5,
      RA_STATUS = 3'd6
   } reg_addr_e;

   // nesting state: two service depths
   typedef enum logic [1:0] {
      NS_IDLE   = 2'd0,
      NS_LO     = 2'd1,
      NS_HI     = 2'd2,
      NS_HI_ON_LO = 2'd3
   } nest_state_e;

   localparam int unsigned ADDR_W      = 3;
   localparam int unsigned FIX_HI_ADDR = 32'h0000_0008;
   localparam int unsigned FIX_LO_ADDR = 32'h0000_0018;

endpackage

// File: rtl/irqv_pick.sv
// Fixed-order picker: lowest set candidate index wins.
module irqv_pick #(
   parameter int unsigned N     = 16,
   parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     cand_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);

   generate
      if (N < 1) begin : g_bad_n
         $error("irqv_pick: N must be at least 1");
      end
      if (N == 1) begin : g_single
         assign any_o = cand_i[0];
         assign idx_o = '0;
      end else begin : g_multi
         always_comb begin
            any_o = 1'b0;
            idx_o = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (cand_i[i]) begin
                  any_o = 1'b1;
                  idx_o = IDX_W'(i);
               end
            end
         end
      end
   endgenerate

   // winner really is a candidate, and nothing below it is
   logic [N-1:0] below_mask;
   assign below_mask = (N'(1) << idx_o) - N'(1);

   assert_pick_valid_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> cand_i[idx_o]);
   assert_pick_lowest_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> ((cand_i & below_mask) == '0));
   assert_pick_none_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (cand_i == '0) |-> !any_o);

endmodule

// File: rtl/irqv_base_lock.sv
// Table base register with write lock and optional one-way lock rule.
module irqv_base_lock #(
   parameter int unsigned      VEC_W    = 21,
   parameter logic [VEC_W-1:0] RST_BASE = VEC_W'(8)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             one_way_i,
   input  logic             base_we_i,
   input  logic [VEC_W-1:0] base_wdata_i,
   input  logic             lock_we_i,
   input  logic             lock_wdata_i,
   output logic [VEC_W-1:0] base_o,
   output logic             lock_o
);

   logic [VEC_W-1:0] base_q;
   logic             lock_q;
   logic             lock_clear_ok;

   assign lock_clear_ok = !(one_way_i && lock_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
      end else if (lock_we_i) begin
         if (lock_wdata_i) begin
            lock_q <= 1'b1;
         end else if (lock_clear_ok) begin
            lock_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= RST_BASE;
      end else if (base_we_i && !lock_q) begin
         base_q <= base_wdata_i;
      end
   end

   assign base_o = base_q;
   assign lock_o = lock_q;

   assert_base_frozen_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> (base_q == $past(base_q)));
   assert_oneway_sticky_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (one_way_i && lock_q) |=> lock_q);
   assert_lock_set_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (lock_we_i && lock_wdata_i) |=> lock_q);

endmodule

// File: rtl/irqv_nest.sv
// Two-depth service tracker: low, high, or high preempting low.
module irqv_nest
   import irqv_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic take_i,
   input  logic take_hi_i,
   input  logic ret_i,
   output logic exec_hi_o,
   output logic exec_lo_o,
   output logic idle_o
);

   nest_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (ret_i) begin
         unique case (state_q)
            NS_HI_ON_LO: state_d = NS_LO;
            NS_HI:       state_d = NS_IDLE;
            NS_LO:       state_d = NS_IDLE;
            default:     state_d = NS_IDLE;
         endcase
      end else if (take_i) begin
         unique case (state_q)
            NS_IDLE: state_d = take_hi_i ? NS_HI : NS_LO;
            NS_LO:   state_d = take_hi_i ? NS_HI_ON_LO : NS_LO;
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= NS_IDLE;
      else        state_q <= state_d;
   end

   assign exec_hi_o = (state_q == NS_HI) || (state_q == NS_HI_ON_LO);
   assign exec_lo_o = (state_q == NS_LO);
   assign idle_o    = (state_q == NS_IDLE);

   // the top only offers entries the current depth allows
   assert_take_legal_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !take_hi_i) |-> (state_q == NS_IDLE));
   assert_take_hi_legal_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && take_hi_i) |-> (state_q == NS_IDLE || state_q == NS_LO));
   assert_ret_pops_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && state_q == NS_HI_ON_LO) |=> (state_q == NS_LO));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irqv_pkg::*;
#(
   parameter int unsigned      N          = 16,
   parameter int unsigned      DATA_W     = 32,
   parameter int unsigned      VEC_W      = 21,
   parameter int unsigned      STEP_SHIFT = 1,
   parameter logic [VEC_W-1:0] RST_BASE   = VEC_W'(8)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        src_irq_i,
   input  logic                vec_mode_i,
   input  logic                one_way_i,
   input  logic                bus_wr_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   output logic [DATA_W-1:0]   bus_rdata_o,
   output logic                core_req_o,
   output logic                core_hi_o,
   output logic [VEC_W-1:0]    core_vec_o,
   input  logic                core_ack_i,
   input  logic                core_ret_i,
   output logic                exec_hi_o,
   output logic                exec_lo_o
);

   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

   generate
      if (N < 1 || N > DATA_W) begin : g_bad_n
         $error("irq_vector_ctrl: N must be 1..DATA_W");
      end
      if (VEC_W > DATA_W || VEC_W <= IDX_W + STEP_SHIFT) begin : g_bad_vec
         $error("irq_vector_ctrl: VEC_W out of range");
      end
      if (DATA_W < 2) begin : g_bad_dw
         $error("irq_vector_ctrl: DATA_W too small");
      end
   endgenerate

   // ---------------- register writes ----------------
   logic wr_gctl, wr_pend, wr_ena, wr_level, wr_base, wr_lock;
   assign wr_gctl  = bus_wr_i && (bus_addr_i == RA_GCTL);
   assign wr_pend  = bus_wr_i && (bus_addr_i == RA_PEND);
   assign wr_ena   = bus_wr_i && (bus_addr_i == RA_ENA);
   assign wr_level = bus_wr_i && (bus_addr_i == RA_LEVEL);
   assign wr_base  = bus_wr_i && (bus_addr_i == RA_BASE);
   assign wr_lock  = bus_wr_i && (bus_addr_i == RA_LOCK);

   logic         gie_hi_q, gie_lo_q;
   logic [N-1:0] pend_q, ena_q, level_q;
   logic [N-1:0] pend_clr;

   assign pend_clr = wr_pend ? bus_wdata_i[N-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_hi_q <= 1'b0;
         gie_lo_q <= 1'b0;
      end else if (wr_gctl) begin
         gie_hi_q <= bus_wdata_i[0];
         gie_lo_q <= bus_wdata_i[1];
      end
   end

   // set from the line has precedence over software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~pend_clr) | src_irq_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ena_q <= '0;
      else if (wr_ena) ena_q <= bus_wdata_i[N-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        level_q <= '1;
      else if (wr_level) level_q <= bus_wdata_i[N-1:0];
   end

   // ---------------- base and lock ----------------
   logic [VEC_W-1:0] base;
   logic             lock;

   irqv_base_lock #(
      .VEC_W   (VEC_W),
      .RST_BASE(RST_BASE)
   ) u_base_lock (
      .clk         (clk),
      .rst_n       (rst_n),
      .one_way_i   (one_way_i),
      .base_we_i   (wr_base),
      .base_wdata_i(bus_wdata_i[VEC_W-1:0]),
      .lock_we_i   (wr_lock),
      .lock_wdata_i(bus_wdata_i[0]),
      .base_o      (base),
      .lock_o      (lock)
   );

   // ---------------- arbitration ----------------
   logic [N-1:0]     live, hi_cand, lo_cand;
   logic             hi_any, lo_any;
   logic [IDX_W-1:0] hi_idx, lo_idx;

   assign live    = pend_q & ena_q;
   assign hi_cand = live & level_q;
   assign lo_cand = live & ~level_q;

   irqv_pick #(.N(N), .IDX_W(IDX_W)) u_pick_hi (
      .clk   (clk),
      .rst_n (rst_n),
      .cand_i(hi_cand),
      .any_o (hi_any),
      .idx_o (hi_idx)
   );

   irqv_pick #(.N(N), .IDX_W(IDX_W)) u_pick_lo (
      .clk   (clk),
      .rst_n (rst_n),
      .cand_i(lo_cand),
      .any_o (lo_any),
      .idx_o (lo_idx)
   );

   // ---------------- nesting ----------------
   logic idle, ex_hi, ex_lo;
   logic hi_go, lo_go, take;
   logic [IDX_W-1:0] win_idx;

   assign hi_go   = hi_any && gie_hi_q && !ex_hi;
   assign lo_go   = lo_any && gie_lo_q && idle;
   assign win_idx = hi_go ? hi_idx : lo_idx;
   assign take    = core_req_o && core_ack_i;

   irqv_nest u_nest (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_i   (take),
      .take_hi_i(hi_go),
      .ret_i    (core_ret_i),
      .exec_hi_o(ex_hi),
      .exec_lo_o(ex_lo),
      .idle_o   (idle)
   );

   // ---------------- vector ----------------
   logic [VEC_W-1:0] tab_vec, fix_vec;
   assign tab_vec = base + (VEC_W'(win_idx) << STEP_SHIFT);
   assign fix_vec = hi_go ? VEC_W'(FIX_HI_ADDR) : VEC_W'(FIX_LO_ADDR);

   assign core_req_o = hi_go || lo_go;
   assign core_hi_o  = hi_go;
   assign core_vec_o = vec_mode_i ? tab_vec : fix_vec;
   assign exec_hi_o  = ex_hi;
   assign exec_lo_o  = ex_lo;

   // ---------------- read port ----------------
   always_comb begin
      bus_rdata_o = '0;
      unique case (bus_addr_i)
         RA_GCTL:   bus_rdata_o = DATA_W'({gie_lo_q, gie_hi_q});
         RA_PEND:   bus_rdata_o = DATA_W'(pend_q);
         RA_ENA:    bus_rdata_o = DATA_W'(ena_q);
         RA_LEVEL:  bus_rdata_o = DATA_W'(level_q);
         RA_BASE:   bus_rdata_o = DATA_W'(base);
         RA_LOCK:   bus_rdata_o = DATA_W'(lock);
         RA_STATUS: bus_rdata_o = DATA_W'({ex_lo, ex_hi});
         default:   bus_rdata_o = '0;
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata_i;

   // ---------------- checks ----------------
   assert_pend_sticky_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_pend |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
   assert_req_enabled_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      core_req_o |-> (pend_q[win_idx] && ena_q[win_idx]));
   assert_hi_first_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (core_req_o && !core_hi_o) |-> !(hi_any && gie_hi_q && !ex_hi));
   assert_gie_gate_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      core_req_o |-> (core_hi_o ? gie_hi_q : gie_lo_q));
   assert_no_req_in_hi_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      ex_hi |-> !core_req_o);
   assert_status_excl_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !(ex_hi && ex_lo));

endmodule

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/100ps
module irq_vector_ctrl_tb;

   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] src = '0;
   logic        vec_mode = 1'b1;
   logic        one_way = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        req, hi, ack = 1'b0, ret = 1'b0, ex_hi, ex_lo;
   logic [20:0] vec;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   irq_vector_ctrl #(.N(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_irq_i(src), .vec_mode_i(vec_mode),
      .one_way_i(one_way), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .core_req_o(req),
      .core_hi_o(hi), .core_vec_o(vec), .core_ack_i(ack), .core_ret_i(ret),
      .exec_hi_o(ex_hi), .exec_lo_o(ex_lo)
   );

   typedef struct packed {
      logic [15:0] ena;
      logic [15:0] lvl;
      logic [15:0] lines;
      logic        vm;
      logic        exp_req;
      logic        exp_hi;
      logic [20:0] exp_vec;
   } vrow_t;

   localparam vrow_t TBL [7] = '{
      '{ena:16'hFFFF, lvl:16'h0000, lines:16'h0030, vm:1'b1, exp_req:1'b1, exp_hi:1'b0, exp_vec:21'h10},
      '{ena:16'hFFFF, lvl:16'h0100, lines:16'h0130, vm:1'b1, exp_req:1'b1, exp_hi:1'b1, exp_vec:21'h18},
      '{ena:16'h0020, lvl:16'h0000, lines:16'h0030, vm:1'b1, exp_req:1'b1, exp_hi:1'b0, exp_vec:21'h12},
      '{ena:16'h0000, lvl:16'h0000, lines:16'hFFFF, vm:1'b1, exp_req:1'b0, exp_hi:1'b0, exp_vec:21'h0},
      '{ena:16'hFFFF, lvl:16'hFFFF, lines:16'h8000, vm:1'b0, exp_req:1'b1, exp_hi:1'b1, exp_vec:21'h8},
      '{ena:16'hFFFF, lvl:16'h0000, lines:16'h8000, vm:1'b0, exp_req:1'b1, exp_hi:1'b0, exp_vec:21'h18},
      '{ena:16'hFFFF, lvl:16'h0C00, lines:16'h0C01, vm:1'b1, exp_req:1'b1, exp_hi:1'b1, exp_vec:21'h1C}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic pulse_src(input logic [N-1:0] s);
      @(negedge clk); src = s;
      @(negedge clk); src = '0;
      #1;
   endtask

   task automatic pulse_ack();
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      #1;
   endtask

   task automatic pulse_ret();
      @(negedge clk); ret = 1'b1;
      @(negedge clk); ret = 1'b0;
      #1;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      rd(3'd0, d); chk("R11 gctl", d, 32'h0);
      rd(3'd1, d); chk("R11 pend", d, 32'h0);
      rd(3'd2, d); chk("R11 ena", d, 32'h0);
      rd(3'd3, d); chk("R11 level", d, 32'hFFFF);
      rd(3'd4, d); chk("R11 base", d, 32'h8);
      rd(3'd5, d); chk("R11 lock", d, 32'h0);
      rd(3'd6, d); chk("R11 status", d, 32'h0);
      chk("R11 req", {31'b0, req}, 32'h0);

      // table walk: R2 R3 R4 R5 R8
      foreach (TBL[i]) begin
         wr(3'd1, 32'hFFFF);
         wr(3'd0, 32'h3);
         wr(3'd2, {16'b0, TBL[i].ena});
         wr(3'd3, {16'b0, TBL[i].lvl});
         vec_mode = TBL[i].vm;
         pulse_src(TBL[i].lines);
         chk($sformatf("R2/R3 req row%0d", i), {31'b0, req}, {31'b0, TBL[i].exp_req});
         if (TBL[i].exp_req) begin
            chk($sformatf("R3 level row%0d", i), {31'b0, hi}, {31'b0, TBL[i].exp_hi});
            chk($sformatf("R4/R5/R8 vec row%0d", i), {11'b0, vec}, {11'b0, TBL[i].exp_vec});
         end
      end
      vec_mode = 1'b1;

      // R1 pending persistence and clear
      wr(3'd1, 32'hFFFF);
      pulse_src(16'h0040);
      rd(3'd1, d); chk("R1 held", d, 32'h40);
      wr(3'd1, 32'h0);
      rd(3'd1, d); chk("R1 zero write", d, 32'h40);
      wr(3'd1, 32'h40);
      rd(3'd1, d); chk("R1 cleared", d, 32'h0);
      @(negedge clk);
      src = 16'h0040; bus_addr = 3'd1; bus_wdata = 32'h40; bus_wr = 1'b1;
      @(negedge clk);
      src = '0; bus_wr = 1'b0;
      rd(3'd1, d); chk("R1 set wins", d, 32'h40);

      // R9 global enables
      wr(3'd1, 32'hFFFF);
      wr(3'd2, 32'hFFFF);
      wr(3'd3, 32'h0);
      wr(3'd0, 32'h1);
      pulse_src(16'h0001);
      chk("R9 low gated", {31'b0, req}, 32'h0);
      wr(3'd0, 32'h3);
      #1 chk("R9 low open", {31'b0, req}, 32'h1);
      wr(3'd3, 32'hFFFF);
      wr(3'd0, 32'h2);
      #1 chk("R9 high gated", {31'b0, req}, 32'h0);

      // R10 nesting
      wr(3'd1, 32'hFFFF);
      wr(3'd0, 32'h3);
      wr(3'd3, 32'h0002);
      pulse_src(16'h0001);
      chk("R10 low req", {30'b0, req, hi}, 32'h2);
      pulse_ack();
      chk("R10 in low", {30'b0, ex_hi, ex_lo}, 32'h1);
      chk("R10 no low in low", {31'b0, req}, 32'h0);
      pulse_src(16'h0002);
      chk("R10 preempt req", {30'b0, req, hi}, 32'h3);
      chk("R10 preempt vec", {11'b0, vec}, 32'hA);
      pulse_ack();
      chk("R10 in high", {30'b0, ex_hi, ex_lo}, 32'h2);
      chk("R10 no req in high", {31'b0, req}, 32'h0);
      rd(3'd6, d); chk("R10 status reg", d, 32'h1);
      pulse_ret();
      chk("R10 back to low", {30'b0, ex_hi, ex_lo}, 32'h1);
      chk("R10 hi again", {30'b0, req, hi}, 32'h3);
      wr(3'd1, 32'h2);
      pulse_ret();
      chk("R10 idle", {30'b0, ex_hi, ex_lo}, 32'h0);
      chk("R10 low again", {30'b0, req, hi}, 32'h2);

      // R6 / R7 lock behaviour
      wr(3'd1, 32'hFFFF);
      wr(3'd3, 32'h0);
      wr(3'd4, 32'h1000);
      rd(3'd4, d); chk("R6 base write", d, 32'h1000);
      pulse_src(16'h0004);
      chk("R5 vec base", {11'b0, vec}, 32'h1004);
      wr(3'd5, 32'h1);
      wr(3'd4, 32'h2000);
      rd(3'd4, d); chk("R6 locked base", d, 32'h1000);
      chk("R6 vec unchanged", {11'b0, vec}, 32'h1004);
      wr(3'd5, 32'h0);
      rd(3'd5, d); chk("R7 lock cleared", d, 32'h0);
      wr(3'd4, 32'h2000);
      rd(3'd4, d); chk("R7 base after unlock", d, 32'h2000);
      one_way = 1'b1;
      wr(3'd5, 32'h1);
      wr(3'd5, 32'h0);
      rd(3'd5, d); chk("R7 one-way stuck", d, 32'h1);
      wr(3'd4, 32'h3000);
      rd(3'd4, d); chk("R7 base stays", d, 32'h2000);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule